// File: doc/BRIEF.md
# Always-On Wake-Up Timer

This block is a 32-bit counter that keeps time on an always-on clock, separate from the gated core bus clock. A prescaler divides the always-on clock before it reaches the counter. The counter can count down or up. It can run free, wrapping past its end value, or it can run periodically, reloading from a software-written value each time it expires. The source oscillator and its selection are outside the block: the block receives the already selected always-on clock on `tmr_clk`.

Software programs the block through a small register window in the bus clock domain. Configuration written there crosses into the timer domain through a toggle handshake. The live count comes back through a second handshake as a coherent snapshot. On expiry the timer domain sets a sticky flag. That flag drives `wake` directly, so it can rouse a sleeping core, and a synchronised copy of it drives the bus-side `irq`. Software acknowledges the interrupt by writing any value to the acknowledge address.

Top module: `wake_timer`

## Requirements
- R1: After reset, the value register reads 0xFFFFFFFF, the reload and mode registers read 0, and both `irq` and `wake` are low.
- R2: The register addresses are 0 for reload (32-bit, read/write), 1 for value (read-only), 2 for mode and 3 for acknowledge (write-only, reads 0). The mode register uses bits [3:0] for the prescale code, bit 4 to select up-counting, bit 5 to select periodic reload and bit 6 to enable counting. Reload and mode read back exactly what was written, with the mode register holding 7 bits.
- R3: While the enable bit is clear the counter does not move, and the value register reads back the reload value.
- R4: When counting down from L with a division of D, the timer expires (L+1)·D timer cycles after counting starts. In free-running mode it then continues from 0xFFFFFFFF.
- R5: In periodic mode, expiry reloads the counter from the reload register, so every value read stays at or below L and the interrupt recurs every (L+1)·D cycles.
- R6: When counting up from L, expiry happens on the tick that leaves 0xFFFFFFFF, (2^32−L)·D cycles after the start. In free-running mode counting then resumes from 0.
- R7: Prescale code 0000 divides by 1, 0100 by 16, 1000 by 256 and 1111 by 32768. Every other code divides by 1.
- R8: Counting and assertion of `wake` continue while the bus clock is stopped.
- R9: A write of any data to the acknowledge address clears the interrupt. `irq` falls within 8 timer cycles unless a new expiry occurs.
- R10: When an acknowledge reaches the timer domain in the same cycle as an expiry, the expiry wins and the flag stays set.
- R11: Successive reads of the value register while counting up are non-decreasing and never exceed the number of timer cycles elapsed since the start, so no read is torn.
- R12: Any write to reload or mode restarts counting from the reload value with a fresh prescaler phase, and the transferred configuration stays stable while the handshake is in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Bus clock; may be stopped |
| tmr_clk | input | 1 | Always-on timer clock (selected source) |
| rst_n | input | 1 | Asynchronous active-low reset, released per domain |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the selected register |
| irq | output | 1 | Interrupt, bus clock domain |
| wake | output | 1 | Expiry flag, timer clock domain |

## Verification
Two events can land in the same timer cycle: an acknowledge arriving from the bus side, and an expiry of the counter. The bench provokes this by running periodic mode with a reload of zero, so that every timer cycle is an expiry. It then writes the acknowledge register and samples `wake` on every following timer cycle, together with the bus-side `irq`. Both must stay high, because the expiry takes priority over the clear. The window checks on interrupt timing and the ordering checks on value reads then confirm that neither function disturbs the other.

// File: rtl/wkt_pkg.sv
package wkt_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned PRE_W  = 15;
  localparam int unsigned MODE_W = 7;

  typedef enum logic [ADDR_W-1:0] {
    SEL_RELOAD = 2'd0,
    SEL_COUNT  = 2'd1,
    SEL_MODE   = 2'd2,
    SEL_ACK    = 2'd3
  } reg_sel_e;

  // Packed from MSB: enable [6], periodic [5], up [4], prescale code [3:0]
  typedef struct packed {
    logic       en;
    logic       periodic;
    logic       up;
    logic [3:0] presc;
  } mode_t;

  // Terminal value of the prescaler phase counter for a prescale code
  function automatic logic [PRE_W-1:0] div_limit(input logic [3:0] code);
    logic [PRE_W-1:0] lim;
    case (code)
      4'b0100: lim = PRE_W'(15);
      4'b1000: lim = PRE_W'(255);
      4'b1111: lim = PRE_W'(32767);
      default: lim = '0;
    endcase
    return lim;
  endfunction
endpackage

// File: rtl/wkt_rst_sync.sv
module wkt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/wkt_sync.sv
module wkt_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] pipe_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe_q[s] <= '0;
          else        pipe_q[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe_q[s] <= '0;
          else        pipe_q[s] <= pipe_q[s-1];
        end
      end
    end
  endgenerate

  assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/wkt_bus_regs.sv
module wkt_bus_regs
  import wkt_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [CNT_W-1:0]         wdata,
  output logic [CNT_W-1:0]         rdata,
  input  logic                     cfg_ack_s,
  output logic                     cfg_req,
  output logic [CNT_W+MODE_W-1:0]  cfg_hold,
  input  logic                     snap_req_s,
  input  logic [CNT_W-1:0]         snap_data,
  output logic                     snap_ack,
  input  logic                     clr_ack_s,
  output logic                     clr_req,
  input  logic                     irq_s,
  output logic                     irq
);
  localparam int unsigned HOLD_W = CNT_W + MODE_W;

  logic [CNT_W-1:0]  reload_q, reload_n;
  logic [MODE_W-1:0] mode_q,   mode_n;
  logic              dirty_q,  dirty_n;
  logic              req_q,    req_n;
  logic [HOLD_W-1:0] hold_q,   hold_n;
  logic [CNT_W-1:0]  value_q,  value_n;
  logic              sack_q,   sack_n;
  logic              cpend_q,  cpend_n;
  logic              creq_q,   creq_n;
  logic              irq_q;

  always_comb begin
    reload_n = reload_q;
    mode_n   = mode_q;
    dirty_n  = dirty_q;
    req_n    = req_q;
    hold_n   = hold_q;
    value_n  = value_q;
    sack_n   = sack_q;
    cpend_n  = cpend_q;
    creq_n   = creq_q;

    // launch a configuration transfer once the previous one is acknowledged
    if (dirty_q && (req_q == cfg_ack_s)) begin
      hold_n  = {reload_q, mode_q};
      req_n   = ~req_q;
      dirty_n = 1'b0;
    end

    // launch an interrupt acknowledge once the previous one completed
    if (cpend_q && (creq_q == clr_ack_s)) begin
      creq_n  = ~creq_q;
      cpend_n = 1'b0;
    end

    // accept an offered snapshot of the counter
    if (snap_req_s != sack_q) begin
      value_n = snap_data;
      sack_n  = ~sack_q;
    end

    if (wr_en) begin
      case (reg_sel_e'(addr))
        SEL_RELOAD: begin
          reload_n = wdata;
          dirty_n  = 1'b1;
        end
        SEL_MODE: begin
          mode_n  = wdata[MODE_W-1:0];
          dirty_n = 1'b1;
        end
        SEL_ACK:  cpend_n = 1'b1;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      mode_q   <= '0;
      dirty_q  <= 1'b0;
      req_q    <= 1'b0;
      hold_q   <= '0;
      value_q  <= '1;
      sack_q   <= 1'b0;
      cpend_q  <= 1'b0;
      creq_q   <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      reload_q <= reload_n;
      mode_q   <= mode_n;
      dirty_q  <= dirty_n;
      req_q    <= req_n;
      hold_q   <= hold_n;
      value_q  <= value_n;
      sack_q   <= sack_n;
      cpend_q  <= cpend_n;
      creq_q   <= creq_n;
      irq_q    <= irq_s;
    end
  end

  always_comb begin
    case (reg_sel_e'(addr))
      SEL_RELOAD: rdata = reload_q;
      SEL_COUNT:  rdata = value_q;
      SEL_MODE:   rdata = {{(CNT_W-MODE_W){1'b0}}, mode_q};
      default:    rdata = '0;
    endcase
  end

  assign cfg_req  = req_q;
  assign cfg_hold = hold_q;
  assign snap_ack = sack_q;
  assign clr_req  = creq_q;
  assign irq      = irq_q;
endmodule

// File: rtl/wkt_core.sv
module wkt_core
  import wkt_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_req_s,
  input  logic [CNT_W+MODE_W-1:0]  cfg_hold,
  output logic                     cfg_ack,
  input  logic                     clr_req_s,
  output logic                     clr_ack,
  input  logic                     snap_ack_s,
  output logic                     snap_req,
  output logic [CNT_W-1:0]         snap_data,
  output logic                     flag
);
  mode_t            mode_q,   mode_n;
  logic [CNT_W-1:0] reload_q, reload_n;
  logic [CNT_W-1:0] cnt_q,    cnt_n;
  logic [PRE_W-1:0] pre_q,    pre_n;
  logic             seen_q,   seen_n;
  logic             cseen_q,  cseen_n;
  logic             flag_q,   flag_n;
  logic             sreq_q,   sreq_n;
  logic [CNT_W-1:0] snap_q,   snap_n;

  logic             cfg_new, clr_new, tick, at_end, fire;
  logic [PRE_W-1:0] pre_lim;

  always_comb begin
    cfg_new = (cfg_req_s != seen_q);
    clr_new = (clr_req_s != cseen_q);
    pre_lim = div_limit(mode_q.presc);
    tick    = mode_q.en && (pre_q == pre_lim);
    at_end  = mode_q.up ? (cnt_q == '1) : (cnt_q == '0);
    fire    = tick && at_end && !cfg_new;

    mode_n   = mode_q;
    reload_n = reload_q;
    cnt_n    = cnt_q;
    pre_n    = pre_q;
    seen_n   = seen_q;
    cseen_n  = clr_req_s;
    sreq_n   = sreq_q;
    snap_n   = snap_q;

    if (cfg_new) begin
      seen_n   = cfg_req_s;
      reload_n = cfg_hold[CNT_W+MODE_W-1:MODE_W];
      mode_n   = mode_t'(cfg_hold[MODE_W-1:0]);
      cnt_n    = cfg_hold[CNT_W+MODE_W-1:MODE_W];
      pre_n    = '0;
    end else if (mode_q.en) begin
      pre_n = tick ? '0 : pre_q + 1'b1;
      if (tick) begin
        if (at_end && mode_q.periodic) cnt_n = reload_q;
        else if (mode_q.up)            cnt_n = cnt_q + 1'b1;
        else                           cnt_n = cnt_q - 1'b1;
      end
    end

    // expiry has priority over an acknowledge landing in the same cycle
    flag_n = (flag_q && !clr_new) || fire;

    if (snap_ack_s == sreq_q) begin
      snap_n = cnt_q;
      sreq_n = ~sreq_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      reload_q <= '0;
      cnt_q    <= '1;
      pre_q    <= '0;
      seen_q   <= 1'b0;
      cseen_q  <= 1'b0;
      flag_q   <= 1'b0;
      sreq_q   <= 1'b0;
      snap_q   <= '1;
    end else begin
      mode_q   <= mode_n;
      reload_q <= reload_n;
      cnt_q    <= cnt_n;
      pre_q    <= pre_n;
      seen_q   <= seen_n;
      cseen_q  <= cseen_n;
      flag_q   <= flag_n;
      sreq_q   <= sreq_n;
      snap_q   <= snap_n;
    end
  end

  assign cfg_ack   = seen_q;
  assign clr_ack   = cseen_q;
  assign snap_req  = sreq_q;
  assign snap_data = snap_q;
  assign flag      = flag_q;
endmodule

// File: rtl/wake_timer.sv
module wake_timer
  import wkt_pkg::*;
#(
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              bus_clk,
  input  logic              tmr_clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic              irq,
  output logic              wake
);
  localparam int unsigned HOLD_W = CNT_W + MODE_W;

  logic              bus_rst_n_s, tmr_rst_n_s;
  logic              cfg_req, cfg_ack, cfg_req_s, cfg_ack_s;
  logic [HOLD_W-1:0] cfg_hold;
  logic              snap_req, snap_ack, snap_req_s, snap_ack_s;
  logic [CNT_W-1:0]  snap_data;
  logic              clr_req, clr_ack, clr_req_s, clr_ack_s;
  logic              irq_s;

  wkt_rst_sync u_bus_rst (.clk(bus_clk), .rst_n(rst_n), .rst_n_sync(bus_rst_n_s));
  wkt_rst_sync u_tmr_rst (.clk(tmr_clk), .rst_n(rst_n), .rst_n_sync(tmr_rst_n_s));

  // timer-domain signals seen by the bus domain
  wkt_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_to_bus (
    .clk   (bus_clk),
    .rst_n (bus_rst_n_s),
    .d     ({cfg_ack, snap_req, clr_ack, wake}),
    .q     ({cfg_ack_s, snap_req_s, clr_ack_s, irq_s})
  );

  // bus-domain signals seen by the timer domain
  wkt_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_to_tmr (
    .clk   (tmr_clk),
    .rst_n (tmr_rst_n_s),
    .d     ({cfg_req, snap_ack, clr_req}),
    .q     ({cfg_req_s, snap_ack_s, clr_req_s})
  );

  wkt_bus_regs #(.CNT_W(CNT_W)) u_regs (
    .clk        (bus_clk),
    .rst_n      (bus_rst_n_s),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .rdata      (rdata),
    .cfg_ack_s  (cfg_ack_s),
    .cfg_req    (cfg_req),
    .cfg_hold   (cfg_hold),
    .snap_req_s (snap_req_s),
    .snap_data  (snap_data),
    .snap_ack   (snap_ack),
    .clr_ack_s  (clr_ack_s),
    .clr_req    (clr_req),
    .irq_s      (irq_s),
    .irq        (irq)
  );

  wkt_core #(.CNT_W(CNT_W)) u_core (
    .clk        (tmr_clk),
    .rst_n      (tmr_rst_n_s),
    .cfg_req_s  (cfg_req_s),
    .cfg_hold   (cfg_hold),
    .cfg_ack    (cfg_ack),
    .clr_req_s  (clr_req_s),
    .clr_ack    (clr_ack),
    .snap_ack_s (snap_ack_s),
    .snap_req   (snap_req),
    .snap_data  (snap_data),
    .flag       (wake)
  );
endmodule

// File: rtl/wkt_checks.sv
module wkt_checks #(
  parameter int unsigned HOLD_W = 39,
  parameter int unsigned CNT_W  = 32
) (
  input logic              bus_clk,
  input logic              tmr_clk,
  input logic              bus_rst_n_s,
  input logic              tmr_rst_n_s,
  input logic              cfg_req,
  input logic              cfg_ack_s,
  input logic [HOLD_W-1:0] cfg_hold,
  input logic              snap_req,
  input logic              snap_ack_s,
  input logic [CNT_W-1:0]  snap_data,
  input logic              clr_req,
  input logic              clr_ack_s,
  input logic              clr_req_s,
  input logic              clr_ack,
  input logic              wake
);
  // R12: the transferred configuration does not move while a transfer is open
  p_cfg_hold_stable_r12: assert property (@(posedge bus_clk) disable iff (!bus_rst_n_s)
    (cfg_req != cfg_ack_s) |=> $stable(cfg_hold));

  // R12: a new configuration transfer only starts from the idle handshake state
  p_cfg_launch_idle_r12: assert property (@(posedge bus_clk) disable iff (!bus_rst_n_s)
    !$stable(cfg_req) |-> $past(cfg_req == cfg_ack_s));

  // R11: the offered snapshot is frozen until the bus side takes it
  p_snap_stable_r11: assert property (@(posedge tmr_clk) disable iff (!tmr_rst_n_s)
    (snap_req != snap_ack_s) |=> $stable(snap_data));

  // R10: without a fresh acknowledge the wake flag stays set
  p_wake_held_r10: assert property (@(posedge tmr_clk) disable iff (!tmr_rst_n_s)
    (wake && (clr_req_s == clr_ack)) |=> wake);

  // R9: an acknowledge is only launched after the previous one completed
  p_clr_launch_idle_r9: assert property (@(posedge bus_clk) disable iff (!bus_rst_n_s)
    !$stable(clr_req) |-> $past(clr_req == clr_ack_s));
endmodule

bind wake_timer wkt_checks #(.HOLD_W(CNT_W + wkt_pkg::MODE_W), .CNT_W(CNT_W)) u_chk (
  .bus_clk     (bus_clk),
  .tmr_clk     (tmr_clk),
  .bus_rst_n_s (bus_rst_n_s),
  .tmr_rst_n_s (tmr_rst_n_s),
  .cfg_req     (cfg_req),
  .cfg_ack_s   (cfg_ack_s),
  .cfg_hold    (cfg_hold),
  .snap_req    (snap_req),
  .snap_ack_s  (snap_ack_s),
  .snap_data   (snap_data),
  .clr_req     (clr_req),
  .clr_ack_s   (clr_ack_s),
  .clr_req_s   (clr_req_s),
  .clr_ack     (clr_ack),
  .wake        (wake)
);

// File: tb/tb_wake_timer.sv
module tb_wake_timer;
  timeunit 1ns;
  timeprecision 100ps;

  localparam real TT = 14.0;   // timer clock period in ns

  logic        bus_clk = 1'b0;
  logic        tmr_clk = 1'b0;
  logic        bus_run = 1'b1;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;
  logic        wake;

  int n_chk = 0;
  int n_err = 0;

  wake_timer dut (
    .bus_clk (bus_clk), .tmr_clk (tmr_clk), .rst_n (rst_n),
    .wr_en   (wr_en),   .addr    (addr),    .wdata (wdata),
    .rdata   (rdata),   .irq     (irq),     .wake  (wake)
  );

  always begin
    #2;
    if (bus_run) bus_clk = ~bus_clk;
  end
  always #7 tmr_clk = ~tmr_clk;

  function automatic int unsigned exp_div(input logic [3:0] code);
    case (code)
      4'b0100: return 16;
      4'b1000: return 256;
      4'b1111: return 32768;
      default: return 1;
    endcase
  endfunction

  function automatic longint unsigned exp_ticks(input logic [31:0] ld, input bit up);
    if (up) return 64'h1_0000_0000 - longint'(ld);
    return longint'(ld) + 1;
  endfunction

  function automatic logic [31:0] mode_word(input bit en, per, up, input logic [3:0] pc);
    return {25'd0, en, per, up, pc};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge bus_clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge bus_clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge bus_clk);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic tw(input real n);
    #(n * TT);
  endtask

  task automatic irq_is(input bit exp, input string req);
    @(negedge bus_clk);
    chk(irq == exp, req, {31'd0, irq}, {31'd0, exp});
  endtask

  task automatic quiesce();
    wr(2'd2, 32'd0);
    tw(20);
    wr(2'd3, 32'hA5);
    tw(20);
  endtask

  // program reload then mode; returns after the mode write
  task automatic start(input logic [31:0] ld, input logic [31:0] md);
    quiesce();
    wr(2'd0, ld);
    tw(20);
    wr(2'd2, md);
  endtask

  initial begin
    #700us;
    n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v, prev;
    longint unsigned n;
    real t0;
    int unsigned sd;
    sd = $urandom(32'd1357);
    wr_en = 1'b0; addr = 2'd0; wdata = '0;
    rst_n = 1'b0;
    #50 rst_n = 1'b1;
    tw(10);

    // R1 reset state
    rd(2'd1, v); chk(v == 32'hFFFF_FFFF, "R1 value", v, 32'hFFFF_FFFF);
    rd(2'd0, v); chk(v == 32'd0, "R1 reload", v, 32'd0);
    rd(2'd2, v); chk(v == 32'd0, "R1 mode", v, 32'd0);
    irq_is(1'b0, "R1 irq");
    chk(wake == 1'b0, "R1 wake", {31'd0, wake}, 32'd0);

    // R2 readback
    wr(2'd0, 32'h1234_5678);
    rd(2'd0, v); chk(v == 32'h1234_5678, "R2 reload", v, 32'h1234_5678);
    wr(2'd2, 32'hFFFF_FF35);
    rd(2'd2, v); chk(v == 32'h35, "R2 mode", v, 32'h35);
    rd(2'd3, v); chk(v == 32'd0, "R2 ack reads 0", v, 32'd0);

    // R3 disabled counter holds reload value
    start(32'd1234, mode_word(0, 0, 0, 4'b0000));
    tw(40);
    rd(2'd1, v); chk(v == 32'd1234, "R3 hold", v, 32'd1234);
    tw(40);
    rd(2'd1, v); chk(v == 32'd1234, "R3 hold later", v, 32'd1234);
    irq_is(1'b0, "R3 no irq");

    // R4 down, free-running, /1
    start(32'd40, mode_word(1, 0, 0, 4'b0000));
    tw(40 - 1); irq_is(1'b0, "R4 before expiry");
    tw(17);     irq_is(1'b1, "R4 after expiry");
    rd(2'd1, v); chk(v >= 32'hFFFF_FF00, "R4 wrap to all ones", v, 32'hFFFF_FFFF);

    // R5 periodic reload, R9 acknowledge
    start(32'd40, mode_word(1, 1, 0, 4'b0000));
    tw(40); irq_is(1'b0, "R5 before first expiry");
    tw(13); irq_is(1'b1, "R5 first expiry");
    wr(2'd3, 32'h0);
    tw(8);  irq_is(1'b0, "R9 cleared");
    for (int i = 0; i < 6; i++) begin
      tw(3);
      rd(2'd1, v); chk(v <= 32'd40, "R5 value within period", v, 32'd40);
    end
    tw(30); irq_is(1'b1, "R5 recurring expiry");

    // R6 up, free-running
    start(32'hFFFF_FFE0, mode_word(1, 0, 1, 4'b0000));
    n = exp_ticks(32'hFFFF_FFE0, 1'b1);
    tw(real'(n) - 1); irq_is(1'b0, "R6 before expiry");
    tw(17);           irq_is(1'b1, "R6 after expiry");
    rd(2'd1, v); chk(v < 32'd64, "R6 wrap to zero", v, 32'd0);

    // R7 prescaler codes
    start(32'd3, mode_word(1, 0, 0, 4'b0100));
    n = exp_ticks(32'd3, 1'b0) * exp_div(4'b0100);
    tw(real'(n) - 1); irq_is(1'b0, "R7 div16 early");
    tw(17);           irq_is(1'b1, "R7 div16 expiry");
    start(32'd0, mode_word(1, 0, 0, 4'b1000));
    n = exp_ticks(32'd0, 1'b0) * exp_div(4'b1000);
    tw(real'(n) - 1); irq_is(1'b0, "R7 div256 early");
    tw(17);           irq_is(1'b1, "R7 div256 expiry");
    start(32'd10, mode_word(1, 0, 0, 4'b0010));
    n = exp_ticks(32'd10, 1'b0) * exp_div(4'b0010);
    tw(real'(n) - 1); irq_is(1'b0, "R7 unlisted code early");
    tw(17);           irq_is(1'b1, "R7 unlisted code as div1");

    // R12 reload write restarts counting
    start(32'd200, mode_word(1, 0, 0, 4'b0000));
    tw(100);
    wr(2'd0, 32'd30);
    tw(29); irq_is(1'b0, "R12 restart early");
    tw(18); irq_is(1'b1, "R12 restart expiry");

    // R8 bus clock stopped
    start(32'd30, mode_word(1, 0, 0, 4'b0000));
    repeat (5) @(negedge bus_clk);
    bus_run = 1'b0;
    tw(60);
    @(negedge tmr_clk);
    chk(wake == 1'b1, "R8 wake while bus stopped", {31'd0, wake}, 32'd1);
    chk(irq == 1'b0, "R8 irq frozen", {31'd0, irq}, 32'd0);
    bus_run = 1'b1;
    tw(5);
    irq_is(1'b1, "R8 irq after resume");

    // R10 acknowledge vs expiry in the same cycle
    start(32'd0, mode_word(1, 1, 0, 4'b0000));
    tw(20);
    wr(2'd3, 32'h5A);
    for (int i = 0; i < 20; i++) begin
      @(negedge tmr_clk);
      chk(wake == 1'b1, "R10 expiry wins", {31'd0, wake}, 32'd1);
    end
    irq_is(1'b1, "R10 irq stays");

    // R11 coherent reads while counting up
    start(32'd0, mode_word(1, 0, 1, 4'b0000));
    t0 = $realtime;
    prev = '0;
    for (int i = 0; i < 20; i++) begin
      repeat ($urandom_range(1, 20)) @(negedge bus_clk);
      rd(2'd1, v);
      n = longint'(($realtime - t0) / TT) + 1;
      chk(v >= prev, "R11 non-decreasing", v, prev);
      chk(longint'(v) <= n, "R11 bounded by elapsed", v, n[31:0]);
      prev = v;
    end

    // random down-count windows (R4, R7, R12)
    for (int i = 0; i < 6; i++) begin
      logic [31:0] ld;
      logic [3:0]  pc;
      ld = $urandom_range(5, 60);
      pc = ($urandom_range(0, 1) == 0) ? 4'b0000 : 4'b0100;
      start(ld, mode_word(1, 0, 0, pc));
      n = exp_ticks(ld, 1'b0) * exp_div(pc);
      tw(real'(n) - 1); irq_is(1'b0, "R4 random early");
      tw(17);           irq_is(1'b1, "R4 random expiry");
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule